// File: doc/BRIEF.md
# One-Shot/Periodic Prescaled Down Timer

This block is a 16-bit down-counter fed by an 8-bit prescaler that acts as its low-order stage. Together they give a range of up to 24 bits. The prescaler counts down from the prescale setting. The main counter steps down by one each time the prescaler passes zero. When both stages sit at zero, the timer has reached its timeout. On the following clock it reloads the interval value and the prescale value. In periodic mode it then keeps running. In one-shot mode it stops and clears its own run bit.

Each timeout sets a sticky raw status flag, which stays set until a write-one clear. A mask bit gates that flag onto a masked status output and an interrupt line. With the trigger enable set, a trigger output is high for exactly the one cycle in which the timer sits at zero. Writing a new interval while the timer runs restarts the count from that value on the next clock. An enabled stall input freezes both stages and holds off new timeouts.

Top module: `pdt_timer`

## Requirements
- R1: After a synchronous active-low reset the timer is stopped (`running_o`=0), `count_o` is 0xFFFF, the interval register holds 0xFFFF, the prescaler is 0, and `raw_o`, `masked_o`, `irq_o` and `trig_o` are 0.
- R2: A cycle with `en_wr_i`=1 loads `en_wdata_i` into the run bit, which `running_o` shows from the next cycle on. A stopped timer holds its count. A timer that is started counts down from whatever it holds.
- R3: While running and not stalled, a nonzero prescaler steps down by one per cycle. When the prescaler is zero and the count is nonzero, the count drops by one and the prescaler restarts at `prescale_i`. As a result the count falls once every `prescale_i`+1 cycles, and a prescale of 0 means it falls on every cycle.
- R4: The timeout state is count 0 together with prescaler 0 while running and not stalled. On the clock after it, the count takes the interval register and the prescaler takes `prescale_i`. With `periodic_i`=1 the timer keeps running, so a period lasts (interval+1)*(prescale+1) cycles.
- R5: With `periodic_i`=0 the timeout reload also clears the run bit, and `count_o` then holds the interval value. An `en_wr_i` in that same cycle takes priority over the automatic clear.
- R6: A timeout sets `raw_o` on the next clock. It stays set until a cycle with `clr_i`=1 clears it. If a clear and a timeout fall in the same cycle, the flag stays set.
- R7: `masked_o` and `irq_o` equal `raw_o` AND `irq_mask_i`.
- R8: `trig_o` is 1 exactly in the cycles in which the timer is in the timeout state while `trig_en_i`=1, and 0 otherwise. Between two timeouts it is therefore low for at least one cycle, unless both the interval and the prescale are 0.
- R9: A cycle with `load_wr_i`=1 writes `load_val_i` into the interval register. On the next clock `count_o` becomes `load_val_i` and the prescaler restarts at `prescale_i`, whether or not the timer runs. This load takes priority over counting and reload, and a running timer continues down from the new value.
- R10: While `stall_en_i`=1 and `stall_i`=1, the count and prescaler hold and no timeout occurs. `stall_i` has no effect while `stall_en_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_wr_i | input | 1 | Write strobe for the run bit |
| en_wdata_i | input | 1 | Value written to the run bit |
| load_wr_i | input | 1 | Write strobe for the interval register |
| load_val_i | input | 16 | New interval value |
| prescale_i | input | 8 | Prescale setting |
| periodic_i | input | 1 | 1 = periodic, 0 = one-shot |
| trig_en_i | input | 1 | Trigger output enable |
| irq_mask_i | input | 1 | Interrupt mask (1 = pass) |
| clr_i | input | 1 | Write-one clear of the timeout flag |
| stall_en_i | input | 1 | Enables the stall input |
| stall_i | input | 1 | Stall request |
| count_o | output | 16 | Current main count |
| running_o | output | 1 | Run bit |
| raw_o | output | 1 | Sticky timeout flag |
| masked_o | output | 1 | Timeout flag after mask |
| irq_o | output | 1 | Interrupt request |
| trig_o | output | 1 | One-cycle timeout trigger |

## Verification
The hardest case to reach from the ports is a clear that lands in the very cycle the timer sits in its timeout state. The outcome depends on the set winning over the clear. The bench steps a cycle model alongside the design and polls that model until it reports the timeout state, then asserts `clr_i` in exactly that cycle. A one-shot stop in the same cycle as a run-bit write, and a stall across several prescaler phases, are reached the same way, by timing the stimulus from the predicted state.

// File: rtl/pdt_pkg.sv
// Shared types for the prescaled down timer.
// Assumes: nothing beyond a standard elaboration order (this file first).
package pdt_pkg;

    // Action taken by the two counting stages on the coming clock edge.
    typedef enum logic [2:0] {
        STEP_HOLD   = 3'd0,  // keep both stages
        STEP_PRE    = 3'd1,  // prescaler steps down, count holds
        STEP_DEC    = 3'd2,  // count steps down, prescaler restarts
        STEP_RELOAD = 3'd3,  // timeout reload from interval and prescale
        STEP_LOAD   = 3'd4   // interval write: load new value, restart prescaler
    } step_e;

endpackage

// File: rtl/pdt_prescaler.sv
// Low-order prescaler stage.
// Follows the step chosen by the top: it restarts at the prescale setting on
// load, reload or a main-count step, and otherwise counts down or holds.
// Assumes: step is STEP_DEC only when this stage already reads zero.
module pdt_prescaler
    import pdt_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_e            step,
    input  logic [PRE_W-1:0] prescale,
    output logic [PRE_W-1:0] pre_q,
    output logic             pre_zero
);

    // Prescaler register update according to the chosen step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            unique case (step)
                STEP_LOAD, STEP_RELOAD, STEP_DEC: pre_q <= prescale;
                STEP_PRE:                         pre_q <= pre_q - 1'b1;
                default:                          pre_q <= pre_q;
            endcase
        end
    end

    // Zero detect feeding the step decision.
    assign pre_zero = (pre_q == '0);

endmodule

// File: rtl/pdt_main_cnt.sv
// Main 16-bit (parameterised) down-count stage.
// Loads the written value, reloads the interval on timeout, or steps down.
// Assumes: step is STEP_DEC only when the count is nonzero.
module pdt_main_cnt
    import pdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_e            step,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] interval,
    output logic [CNT_W-1:0] cnt_q,
    output logic             cnt_zero
);

    // Count register update according to the chosen step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '1;
        end else begin
            unique case (step)
                STEP_LOAD:   cnt_q <= load_val;
                STEP_RELOAD: cnt_q <= interval;
                STEP_DEC:    cnt_q <= cnt_q - 1'b1;
                default:     cnt_q <= cnt_q;
            endcase
        end
    end

    // Zero detect feeding the step decision.
    assign cnt_zero = (cnt_q == '0);

endmodule

// File: rtl/pdt_status.sv
// Timeout status: sticky raw flag with write-one clear (set wins),
// mask gating and the one-cycle trigger.
// Assumes: timeout is high only in cycles the timer sits in its zero state.
module pdt_status (
    input  logic clk,
    input  logic rst_n,
    input  logic timeout,
    input  logic clr,
    input  logic mask,
    input  logic trig_en,
    output logic raw,
    output logic masked,
    output logic trig
);

    // Sticky flag: a timeout in the same cycle as a clear keeps it set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw <= 1'b0;
        end else if (timeout) begin
            raw <= 1'b1;
        end else if (clr) begin
            raw <= 1'b0;
        end
    end

    // Mask gating and trigger, both combinational on current state.
    always_comb begin
        masked = raw & mask;
        trig   = timeout & trig_en;
    end

endmodule

// File: rtl/pdt_timer.sv
// One-shot/periodic prescaled down timer (top).
// Owns the run bit and the interval register, decides one step per cycle for
// the prescaler and the main count, and feeds the timeout to the status block.
// Assumes: all control inputs are synchronous to clk.
module pdt_timer
    import pdt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr_i,
    input  logic             en_wdata_i,
    input  logic             load_wr_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [PRE_W-1:0] prescale_i,
    input  logic             periodic_i,
    input  logic             trig_en_i,
    input  logic             irq_mask_i,
    input  logic             clr_i,
    input  logic             stall_en_i,
    input  logic             stall_i,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o,
    output logic             raw_o,
    output logic             masked_o,
    output logic             irq_o,
    output logic             trig_o
);

    logic             en_q;
    logic [CNT_W-1:0] ilr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PRE_W-1:0] pre_q;
    logic             cnt_zero;
    logic             pre_zero;
    logic             stalled;
    logic             tick;
    logic             at_zero;
    logic             timeout;
    step_e            step;

    // Stall qualification and timeout-state detection.
    always_comb begin
        stalled = stall_en_i & stall_i;
        tick    = en_q & ~stalled;
        at_zero = cnt_zero & pre_zero;
        timeout = tick & at_zero;
    end

    // One step per cycle: a write wins, then hold, reload, count step, prescale step.
    always_comb begin
        if (load_wr_i)       step = STEP_LOAD;
        else if (!tick)      step = STEP_HOLD;
        else if (at_zero)    step = STEP_RELOAD;
        else if (pre_zero)   step = STEP_DEC;
        else                 step = STEP_PRE;
    end

    // Run bit: a write wins, otherwise a one-shot timeout clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (en_wr_i) begin
            en_q <= en_wdata_i;
        end else if (timeout && !periodic_i) begin
            en_q <= 1'b0;
        end
    end

    // Interval register written by the load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ilr_q <= '1;
        end else if (load_wr_i) begin
            ilr_q <= load_val_i;
        end
    end

    pdt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .prescale (prescale_i),
        .pre_q    (pre_q),
        .pre_zero (pre_zero)
    );

    pdt_main_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .load_val (load_val_i),
        .interval (ilr_q),
        .cnt_q    (cnt_q),
        .cnt_zero (cnt_zero)
    );

    pdt_status u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .timeout (timeout),
        .clr     (clr_i),
        .mask    (irq_mask_i),
        .trig_en (trig_en_i),
        .raw     (raw_o),
        .masked  (masked_o),
        .trig    (trig_o)
    );

    // Output mapping.
    always_comb begin
        count_o   = cnt_q;
        running_o = en_q;
        irq_o     = masked_o;
    end

endmodule

// File: rtl/pdt_timer_chk.sv
// Property checker for pdt_timer, attached with bind below.
// Assumes: observes only ports plus the interval register and zero state.
module pdt_timer_chk #(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_wr_i,
    input logic             load_wr_i,
    input logic [CNT_W-1:0] load_val_i,
    input logic [PRE_W-1:0] prescale_i,
    input logic             periodic_i,
    input logic             clr_i,
    input logic             stall_en_i,
    input logic             stall_i,
    input logic [CNT_W-1:0] count_o,
    input logic             running_o,
    input logic             raw_o,
    input logic             irq_o,
    input logic             trig_o,
    input logic [CNT_W-1:0] ilr_q,
    input logic             at_zero
);

    logic stl;
    assign stl = stall_en_i & stall_i;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        running_o && !stl && !load_wr_i && !at_zero |=>
        (count_o == $past(count_o) || count_o == CNT_W'($past(count_o) - 1'b1))); // R3

    AST_TIMEOUT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        running_o && at_zero && !stl && !load_wr_i |=> count_o == $past(ilr_q)); // R4

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        running_o && at_zero && !stl && !periodic_i && !en_wr_i |=> !running_o); // R5

    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        raw_o && !clr_i |=> raw_o); // R6

    AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> raw_o); // R7

    AST_TRIG_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> (count_o == '0 && running_o)); // R8

    AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o && !load_wr_i && (ilr_q != '0 || prescale_i != '0) |=> !trig_o); // R8

    AST_LIVE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr_i |=> count_o == $past(load_val_i)); // R9

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        running_o && stl && !load_wr_i |=> $stable(count_o) && !$rose(raw_o)); // R10

endmodule

bind pdt_timer pdt_timer_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_wr_i    (en_wr_i),
    .load_wr_i  (load_wr_i),
    .load_val_i (load_val_i),
    .prescale_i (prescale_i),
    .periodic_i (periodic_i),
    .clr_i      (clr_i),
    .stall_en_i (stall_en_i),
    .stall_i    (stall_i),
    .count_o    (count_o),
    .running_o  (running_o),
    .raw_o      (raw_o),
    .irq_o      (irq_o),
    .trig_o     (trig_o),
    .ilr_q      (ilr_q),
    .at_zero    (at_zero)
);

// File: tb/pdt_timer_tb.sv
// Scoreboard bench: the driver steps a cycle model built from the
// requirements and queues the expected outputs; the monitor compares them.
module pdt_timer_tb;

    typedef struct {
        string       tag;
        logic [15:0] cnt;
        logic        run;
        logic        raw;
        logic        msk;
        logic        trg;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_wr_i = 0, en_wdata_i = 0, load_wr_i = 0;
    logic [15:0] load_val_i = '0;
    logic [7:0]  prescale_i = '0;
    logic        periodic_i = 0, trig_en_i = 0, irq_mask_i = 0, clr_i = 0;
    logic        stall_en_i = 0, stall_i = 0;
    logic [15:0] count_o;
    logic        running_o, raw_o, masked_o, irq_o, trig_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    exp_t q[$];

    // model state
    logic        m_en = 0;
    logic [15:0] m_cnt = 16'hFFFF;
    logic [15:0] m_ilr = 16'hFFFF;
    logic [7:0]  m_pre = '0;
    logic        m_raw = 0;

    always #10 clk = ~clk;

    pdt_timer u_dut (
        .clk(clk), .rst_n(rst_n), .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
        .load_wr_i(load_wr_i), .load_val_i(load_val_i), .prescale_i(prescale_i),
        .periodic_i(periodic_i), .trig_en_i(trig_en_i), .irq_mask_i(irq_mask_i),
        .clr_i(clr_i), .stall_en_i(stall_en_i), .stall_i(stall_i),
        .count_o(count_o), .running_o(running_o), .raw_o(raw_o),
        .masked_o(masked_o), .irq_o(irq_o), .trig_o(trig_o)
    );

    // monitor: pops one expected item per cycle and compares
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            bit bad;
            e = q.pop_front();
            checks++;
            bad = (count_o !== e.cnt) || (running_o !== e.run) || (raw_o !== e.raw) ||
                  (masked_o !== e.msk) || (irq_o !== e.msk) || (trig_o !== e.trg);
            if (bad) begin
                errors++;
                $display("FAIL %s: cnt=%h run=%b raw=%b msk=%b irq=%b trg=%b expected cnt=%h run=%b raw=%b msk=%b irq=%b trg=%b",
                         e.tag, count_o, running_o, raw_o, masked_o, irq_o, trig_o,
                         e.cnt, e.run, e.raw, e.msk, e.msk, e.trg);
            end
        end
    end

    function automatic logic m_zero();
        return (m_cnt == 16'd0) && (m_pre == 8'd0);
    endfunction

    // push expected outputs for the post-edge state and current inputs
    task automatic push_exp(input string tag);
        exp_t e;
        logic stl;
        stl = stall_en_i & stall_i;
        e.tag = tag;
        e.cnt = m_cnt;
        e.run = m_en;
        e.raw = m_raw;
        e.msk = m_raw & irq_mask_i;
        e.trg = m_en & ~stl & m_zero() & trig_en_i;
        q.push_back(e);
    endtask

    // driver: one clock with the current inputs, model advanced per R2..R10
    task automatic step(input string tag);
        logic        stl, ev, n_en, n_raw;
        logic [15:0] n_cnt, n_ilr;
        logic [7:0]  n_pre;
        stl = stall_en_i & stall_i;
        ev  = m_en & ~stl & m_zero();
        n_en = m_en; n_cnt = m_cnt; n_pre = m_pre; n_ilr = m_ilr; n_raw = m_raw;
        if (m_en && !stl) begin
            if (m_zero()) begin
                n_cnt = m_ilr; n_pre = prescale_i;
                if (!periodic_i) n_en = 1'b0;
            end else if (m_pre == 8'd0) begin
                n_cnt = m_cnt - 16'd1; n_pre = prescale_i;
            end else begin
                n_pre = m_pre - 8'd1;
            end
        end
        if (load_wr_i) begin
            n_ilr = load_val_i; n_cnt = load_val_i; n_pre = prescale_i;
        end
        if (en_wr_i) n_en = en_wdata_i;
        if (clr_i) n_raw = 1'b0;
        if (ev) n_raw = 1'b1;
        m_en = n_en; m_cnt = n_cnt; m_pre = n_pre; m_ilr = n_ilr; m_raw = n_raw;
        push_exp(tag);
        @(negedge clk);
        #1;
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    initial begin
        @(negedge clk); #1;
        // R1: reset state
        push_exp("R1"); @(negedge clk); #1;
        push_exp("R1"); @(negedge clk); #1;
        rst_n = 1'b1;
        run(3, "R1");

        // R9 write while stopped, R2 start, R3/R4/R8 periodic counting
        prescale_i = 8'd2; load_val_i = 16'd3; load_wr_i = 1; step("R9"); load_wr_i = 0;
        run(4, "R2");
        periodic_i = 1; trig_en_i = 1;
        en_wr_i = 1; en_wdata_i = 1; step("R2"); en_wr_i = 0;
        run(14, "R3");
        run(26, "R4");

        // R6 clear and stickiness, R7 mask
        clr_i = 1; step("R6"); clr_i = 0;
        run(15, "R6");
        irq_mask_i = 1; run(15, "R7");
        clr_i = 1; step("R7"); clr_i = 0;
        run(5, "R7");

        // R9 live reload
        load_val_i = 16'd5; load_wr_i = 1; step("R9"); load_wr_i = 0;
        run(10, "R9");

        // R10 stall, then stall without enable
        stall_en_i = 1; stall_i = 1; run(8, "R10");
        stall_i = 0; run(5, "R10");
        stall_en_i = 0; stall_i = 1; run(30, "R10");
        stall_i = 0;
        // stall across the timeout state
        for (int i = 0; i < 60 && !m_zero(); i++) step("R10");
        stall_en_i = 1; stall_i = 1; run(4, "R10");
        stall_en_i = 0; stall_i = 0; run(3, "R10");

        // R6: clear in the same cycle as a timeout, set wins
        prescale_i = 8'd0; load_val_i = 16'd2; load_wr_i = 1; step("R9"); load_wr_i = 0;
        clr_i = 1; step("R6"); clr_i = 0;
        for (int i = 0; i < 50 && !(m_en && m_zero()); i++) step("R6");
        clr_i = 1; step("R6"); clr_i = 0;
        run(4, "R6");

        // R8 trigger disabled
        trig_en_i = 0; run(10, "R8");
        trig_en_i = 1;

        // R5 one-shot
        prescale_i = 8'd1; periodic_i = 0; run(30, "R5");
        en_wr_i = 1; en_wdata_i = 1; step("R5"); en_wr_i = 0;
        run(25, "R5");
        // R5: run-bit write in the stop cycle wins
        en_wr_i = 1; en_wdata_i = 1; step("R5"); en_wr_i = 0;
        for (int i = 0; i < 50 && !(m_en && m_zero()); i++) step("R5");
        en_wr_i = 1; en_wdata_i = 1; step("R5"); en_wr_i = 0;
        run(5, "R5");

        // R2 stop by write
        periodic_i = 1;
        en_wr_i = 1; en_wdata_i = 0; step("R2"); en_wr_i = 0;
        run(6, "R2");

        // R8 both zero: trigger stays high every cycle
        prescale_i = 8'd0; load_val_i = 16'd0; load_wr_i = 1; step("R8"); load_wr_i = 0;
        en_wr_i = 1; en_wdata_i = 1; step("R8"); en_wr_i = 0;
        run(5, "R8");

        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule